// File: doc/BRIEF.md
# Trimmed Square-Wave Generator

This block drives a single square-wave pin from the real-time-clock input clock (nominally 32768 Hz). A two-bit rate selector picks one of four outputs. Two of them are compensated: a 1 Hz and a 512 Hz wave, both built by dividing a corrected reference tick stream. The other two are uncorrected: a 4 kHz wave taken straight from the reference prescaler, and a plain divide-by-eight of the input clock.

Correction is digital. A prescaler makes one reference tick every eight input cycles (4096 Hz). A signed eight-bit trim word (two's complement, one part per million per step) feeds a phase accumulator. The accumulator adds the trim magnitude on every reference tick. Each time the sum reaches the scale constant (one million by default), one reference tick is removed for positive trim, or one extra tick is added for negative trim. The accumulator then drops back by the scale constant. The correction is capped at 127 ppm in either direction.

The output is held low whenever the enable is 0. A change of the rate selector restarts every output divider and forces the pin low before the new rate begins.

Top module: `sqw_trim_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sqw_o` is 0.
- R2: While `en_i` is 0, `sqw_o` is 0 from the cycle after and never toggles.
- R3: Selector value 3 gives the input clock divided by CLK_DIV (default 8): a 50% wave, high for CLK_DIV/2 cycles and low for CLK_DIV/2 cycles. Trim has no effect on it.
- R4: Selector value 2 gives the uncorrected reference wave with period REF_DIV (default 8) input cycles. Trim has no effect on it.
- R5: Selector value 1 gives the compensated 512 Hz wave. It toggles once per REF_HZ/1024 corrected ticks (4 by default), so its period is 64 input cycles with zero trim. The wave rises only after a corrected tick.
- R6: Selector value 0 gives the compensated 1 Hz wave. It toggles once per REF_HZ/2 corrected ticks (2048 by default).
- R7: With trim t > 0, the accumulator adds t on each reference tick and stays below PPM_SCALE. Each time the sum reaches PPM_SCALE, that reference tick is dropped. Over N reference ticks, about N·(1 − t/PPM_SCALE) corrected ticks remain. No corrected tick ever occurs without a reference tick.
- R8: With trim t < 0, each time the sum of |t| reaches PPM_SCALE, one extra corrected tick is produced on the cycle after the reference tick. Over N reference ticks, about N·(1 + |t|/PPM_SCALE) corrected ticks occur.
- R9: Trim value −128 (8'h80) is treated as −127, so the correction never exceeds 127 ppm.
- R10: A change of the selector while enabled drives `sqw_o` to 0 on the next cycle and restarts all dividers. The new rate then begins from a low level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | RTC input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Output enable; 0 holds the pin low |
| sel_i | input | 2 | Rate: 0 = 1 Hz comp., 1 = 512 Hz comp., 2 = 4 kHz, 3 = clock/8 |
| trim_i | input | 8 | Two's-complement ppm trim |
| sqw_o | output | 1 | Square-wave output |

## Verification
The assertions assume that PPM_SCALE is well above 127, so at most one tick is added or removed per reference tick. They also assume REF_DIV is at least two, so an inserted tick can never coincide with the next reference tick. The elaboration checks enforce both assumptions.

The stimulus changes `sel_i`, `trim_i` and `en_i` only between clock edges and waits for the dividers to settle before counting toggles. Toggle counts are compared within one toggle, which absorbs the unknown starting phase of the accumulator and the dividers. The −128 case uses a window long enough that treating the value as −128 instead of −127 would miss that margin.

// File: rtl/sqw_trim_pkg.sv
package sqw_trim_pkg;

   typedef enum logic [1:0] {
      RATE_1HZ  = 2'd0,
      RATE_512  = 2'd1,
      RATE_REF  = 2'd2,
      RATE_DIV  = 2'd3
   } rate_e;

   // magnitude of a two's-complement trim word, saturated so that the
   // most negative code maps onto the largest positive magnitude
   function automatic logic [7:0] trim_mag(input logic [7:0] t);
      logic [7:0] m;
      if (t == 8'h80)       m = 8'd127;
      else if (t[7])        m = (~t) + 8'd1;
      else                  m = t;
      return m;
   endfunction

endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
   parameter int DIV = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o,
   output logic phase_o
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_bad_div
      $error("sqw_prescaler: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (cnt_q == CW'(DIV - 1)) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign tick_o  = (cnt_q == CW'(DIV - 1));
   assign phase_o = (cnt_q < CW'(DIV / 2));

   assert_tick_spaced_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o)
      else $error("reference ticks adjacent");

endmodule

// File: rtl/sqw_trim_accum.sv
module sqw_trim_accum #(
   parameter int TRIM_W    = 8,
   parameter int PPM_SCALE = 1000000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ref_tick_i,
   input  logic [TRIM_W-1:0] trim_i,
   output logic              comp_tick_o
);
   import sqw_trim_pkg::*;

   localparam int AW = $clog2(PPM_SCALE) + 1;

   if (TRIM_W != 8) begin : g_bad_w
      $error("sqw_trim_accum: TRIM_W must be 8");
   end
   if (PPM_SCALE <= 254) begin : g_bad_scale
      $error("sqw_trim_accum: PPM_SCALE too small");
   end

   logic [AW-1:0] acc_q;
   logic [AW:0]   sum;
   logic          wrap;
   logic          neg;
   logic          pend_q;

   assign neg  = trim_i[TRIM_W-1];
   assign sum  = {1'b0, acc_q} + (AW+1)'(trim_mag(trim_i));
   assign wrap = (sum >= (AW+1)'(PPM_SCALE));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= ref_tick_i && wrap && neg;
         if (ref_tick_i) begin
            if (wrap) acc_q <= AW'(sum - (AW+1)'(PPM_SCALE));
            else      acc_q <= AW'(sum);
         end
      end
   end

   assign comp_tick_o = (ref_tick_i && !(wrap && !neg)) || pend_q;

   assert_acc_in_range_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_q < AW'(PPM_SCALE))
      else $error("accumulator out of range");

   assert_pos_no_insert_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!neg && comp_tick_o) |-> ref_tick_i)
      else $error("tick without reference under positive trim");

   assert_insert_after_ref_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (comp_tick_o && !ref_tick_i) |-> $past(ref_tick_i))
      else $error("inserted tick not adjacent to a reference tick");

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
   parameter int HALF = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic tick_i,
   output logic q_o
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   if (HALF < 1) begin : g_bad_half
      $error("sqw_divider: HALF must be positive");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || restart_i) begin
         cnt_q <= '0;
         q_o   <= 1'b0;
      end else if (tick_i) begin
         if (cnt_q == CW'(HALF - 1)) begin
            cnt_q <= '0;
            q_o   <= ~q_o;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assert_rise_on_tick_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(q_o) |-> $past(tick_i))
      else $error("divider rose without a tick");

endmodule

// File: rtl/sqw_trim_gen.sv
module sqw_trim_gen #(
   parameter int CLK_HZ    = 32768,
   parameter int REF_DIV   = 8,
   parameter int CLK_DIV   = 8,
   parameter int PPM_SCALE = 1000000,
   parameter int TRIM_W    = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic [1:0]        sel_i,
   input  logic [TRIM_W-1:0] trim_i,
   output logic              sqw_o
);
   import sqw_trim_pkg::*;

   localparam int REF_HZ = CLK_HZ / REF_DIV;
   localparam int NCOMP  = 2;
   localparam int COMP_HALF [NCOMP] = '{REF_HZ / 2, REF_HZ / 1024};

   if (CLK_HZ % REF_DIV != 0 || REF_HZ % 1024 != 0) begin : g_bad_rate
      $error("sqw_trim_gen: reference rate must be a multiple of 1024 Hz");
   end
   if (CLK_DIV < 2 || CLK_DIV % 2 != 0) begin : g_bad_cdiv
      $error("sqw_trim_gen: CLK_DIV must be even and at least 2");
   end

   logic       ref_tick, ref_phase, comp_tick;
   logic [1:0] sel_q;
   logic       restart;
   logic       div_q;
   logic [NCOMP-1:0] comp_q;
   logic       mux_q;
   logic       out_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) sel_q <= sel_i;
      else         sel_q <= sel_i;
   end

   assign restart = !en_i || (sel_i != sel_q);

   sqw_prescaler #(.DIV(REF_DIV)) u_pre (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_o  (ref_tick),
      .phase_o (ref_phase)
   );

   sqw_trim_accum #(.TRIM_W(TRIM_W), .PPM_SCALE(PPM_SCALE)) u_acc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ref_tick_i  (ref_tick),
      .trim_i      (trim_i),
      .comp_tick_o (comp_tick)
   );

   for (genvar g = 0; g < NCOMP; g++) begin : g_comp
      sqw_divider #(.HALF(COMP_HALF[g])) u_div (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .restart_i (restart),
         .tick_i    (comp_tick),
         .q_o       (comp_q[g])
      );
   end

   sqw_divider #(.HALF(CLK_DIV / 2)) u_cdiv (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .tick_i    (1'b1),
      .q_o       (div_q)
   );

   always_comb begin
      unique case (rate_e'(sel_q))
         RATE_1HZ: mux_q = comp_q[0];
         RATE_512: mux_q = comp_q[1];
         RATE_REF: mux_q = ref_phase;
         default:  mux_q = div_q;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni || restart) out_q <= 1'b0;
      else                    out_q <= mux_q;
   end

   assign sqw_o = out_q;

   assert_disabled_low_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !sqw_o)
      else $error("output not low while disabled");

   assert_sel_change_low_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i != sel_q) |=> !sqw_o)
      else $error("output not low after rate change");

endmodule

// File: tb/sqw_trim_gen_tb.sv
module sqw_trim_gen_tb_top;

   localparam int SCALE = 1000;
   localparam int NV = 11;
   // selector, trim, window (cycles), expected toggles (tolerance 1)
   localparam int V_SEL  [NV] = '{3, 2, 2, 1, 1, 1, 1, 0, 0, 3, 1};
   localparam int V_TRIM [NV] = '{0, 0, 100, 0, 100, -100, 127, 0, 500, -100, -128};
   localparam int V_WIN  [NV] = '{800, 800, 800, 8000, 8000, 8000, 8000,
                                  32768, 32768, 800, 48000};
   localparam int V_EXP  [NV] = '{200, 200, 200, 250, 225, 275, 218, 2, 1, 200, 1690};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [1:0] sel = 2'd3;
   logic [7:0] trim = 8'd0;
   logic       sqw;
   int         n_run = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   sqw_trim_gen #(.PPM_SCALE(SCALE)) dut_i (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .en_i   (en),
      .sel_i  (sel),
      .trim_i (trim),
      .sqw_o  (sqw)
   );

   task automatic check(input string req, input int act, input int exp, input int tol);
      n_run++;
      if (act < exp - tol || act > exp + tol) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (+/-%0d)", req, act, exp, tol);
      end
   endtask

   task automatic count_toggles(input int win, output int n);
      logic prev;
      n = 0;
      @(negedge clk);
      prev = sqw;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (sqw != prev) n++;
         prev = sqw;
      end
   endtask

   function automatic string req_of(input int s, input int t);
      if (t == -128) return "R9";
      if (s == 3) return "R3";
      if (s == 2) return "R4";
      if (t > 0) return "R7";
      if (t < 0) return "R8";
      if (s == 1) return "R5";
      return "R6";
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      int n;
      int hi;
      repeat (4) @(negedge clk);
      check("R1 low in reset", int'(sqw), 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 low after reset", int'(sqw), 0, 0);

      // R2: disabled output never toggles
      count_toggles(200, n);
      check("R2 toggles while disabled", n, 0, 0);
      check("R2 level while disabled", int'(sqw), 0, 0);

      // table of rate/trim vectors
      en = 1'b1;
      for (int k = 0; k < NV; k++) begin
         sel  = 2'(V_SEL[k]);
         trim = 8'(V_TRIM[k]);
         repeat (40) @(negedge clk);
         count_toggles(V_WIN[k], n);
         check(req_of(V_SEL[k], V_TRIM[k]), n, V_EXP[k], 1);
      end

      // R3: 50% duty, high for 4 cycles
      sel = 2'd3;
      trim = 8'd0;
      repeat (20) @(negedge clk);
      while (sqw) @(negedge clk);
      while (!sqw) @(negedge clk);
      hi = 0;
      while (sqw) begin
         hi++;
         @(negedge clk);
      end
      check("R3 high time", hi, 4, 0);

      // R10: rate change while high forces low and restarts slow divider
      while (!sqw) @(negedge clk);
      sel = 2'd1;
      @(negedge clk);
      check("R10 low after select change", int'(sqw), 0, 0);
      count_toggles(18, n);
      check("R10 restart holds low", n + int'(sqw), 0, 0);

      // R2: disabling while running takes the pin low next cycle
      sel = 2'd3;
      repeat (10) @(negedge clk);
      while (!sqw) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check("R2 low after disable", int'(sqw), 0, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule